// File: doc/BRIEF.md
# Indexed Display Register Port

This block is the host-facing register file of a display controller. The host reaches it with single 32-bit port accesses. It first writes a register number to the index port, then reads or writes the value port. A third port, the firmware port, is decoded but carries no function. The distance between the three ports is set at build time by a stride parameter.

Behind the value port sit several groups of registers:
- a version-handshake register;
- the enable and configuration-complete flags;
- the width and height mode registers, each with a range check;
- read-only values derived from the mode, such as depth, pitch and capability bits;
- cursor identity, position and visibility;
- a sync register that starts the command engine with a one-cycle pulse;
- a palette window that reads as zero;
- a window of general-purpose scratch words.

Mode, enable, cursor and sync state is driven out on dedicated outputs so that the display pipeline and command engine can use it.

Top module: `dispreg_port`

## Requirements
- R1: The host port offset selects the target. Offset 0 is the index port, offset STRIDE is the value port and offset 2*STRIDE is the firmware port. A read from the firmware port returns 0, and a write to it is ignored. A read from any other offset returns 0xFFFFFFFF.
- R2: A write to the index port stores the 32-bit register number, and a read from the index port returns it. Reset clears it to 0.
- R3: Register 0 holds the version code 0x90000000 | VERSION, and resets to that value. A write is accepted only when the value is 0x90000000, 0x90000001 or 0x90000002. Any other value leaves the register unchanged.
- R4: Register 2 (width) and register 3 (height) reset to DEF_WIDTH and DEF_HEIGHT and drive width_o and height_o. A write larger than MAX_WIDTH or MAX_HEIGHT is ignored. Registers 4 and 5 read MAX_WIDTH and MAX_HEIGHT.
- R5: Register 7 reads PIX_BITS. Register 6 (depth) reads 24 when PIX_BITS is 32, and PIX_BITS otherwise. Register 12 (pitch) reads PIX_BITS*width/8 for the current width.
- R6: Register 17 (capabilities) reads bits 0 and 1 set (rectangle fill and rectangle copy). It also reads bits 5, 6 and 7 set (cursor and the two cursor-bypass modes) when CURSOR_CAP is 1.
- R7: Register 1 (enable) and register 20 (configuration complete) each store 1 for a nonzero write and 0 for a zero write. Both reset to 0, read back their stored value and drive enable_o and config_o.
- R8: A value-port write to register 21 raises sync_o for exactly the one cycle after the write. A write to any other register does not raise sync_o.
- R9: Registers 24, 25 and 26 (cursor id, x and y) store full 32-bit values, read them back and drive cur_id_o, cur_x_o and cur_y_o.
- R10: A write to register 27 (cursor on) acts by code. Code 1 sets the visible flag, code 0 clears it, and every other code leaves it unchanged. cur_upd_o pulses in the cycle after the write only for codes 0 and 1. Register 27 reads back the visible flag.
- R11: Registers 1024 to 1791 (palette window) read 0, and writes to them are ignored.
- R12: Registers 1792 to 1792+SCRATCH_N-1 are read/write scratch words that reset to 0. An index at or beyond 1792+SCRATCH_N reads 0 and ignores writes. Register 29 reads SCRATCH_N.
- R13: A read of any unlisted register returns 0, and a write to one changes no state.
- R14: Read data is registered. rdata_o takes the addressed value at the clock edge that samples rd_i, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Port byte offset |
| wr_i | input | 1 | Port write strobe |
| rd_i | input | 1 | Port read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| enable_o | output | 1 | Enable flag |
| config_o | output | 1 | Configuration-complete flag |
| width_o | output | DIM_W | Current mode width |
| height_o | output | DIM_W | Current mode height |
| sync_o | output | 1 | One-cycle command-engine start pulse |
| cur_id_o | output | 32 | Cursor identifier |
| cur_x_o | output | 32 | Cursor x position |
| cur_y_o | output | 32 | Cursor y position |
| cur_on_o | output | 1 | Cursor visible flag |
| cur_upd_o | output | 1 | Cursor position/visibility update pulse |

## Verification
The bench builds the block with these parameters:
- STRIDE 4 and ADDR_W 4;
- SCRATCH_N 8;
- MAX_WIDTH 64 and MAX_HEIGHT 40;
- PIX_BITS 32.

With these values every one of the sixteen port offsets can be read, and the width and height can be swept past their limits one step at a time. The whole scratch window, plus the indices on either side of it, can be written and read back. Pitch and depth are checked arithmetically against each accepted width. All cursor-on codes are applied from both flag states, and the version register is swept across the codes just around the valid range.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

  typedef enum logic [1:0] {
    PORT_IDX  = 2'd0,
    PORT_VAL  = 2'd1,
    PORT_FW   = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_ENABLE  = 32'd1;
  localparam logic [31:0] IX_WIDTH   = 32'd2;
  localparam logic [31:0] IX_HEIGHT  = 32'd3;
  localparam logic [31:0] IX_MAXW    = 32'd4;
  localparam logic [31:0] IX_MAXH    = 32'd5;
  localparam logic [31:0] IX_DEPTH   = 32'd6;
  localparam logic [31:0] IX_BPP     = 32'd7;
  localparam logic [31:0] IX_PITCH   = 32'd12;
  localparam logic [31:0] IX_CAPS    = 32'd17;
  localparam logic [31:0] IX_CONFIG  = 32'd20;
  localparam logic [31:0] IX_SYNC    = 32'd21;
  localparam logic [31:0] IX_CUR_ID  = 32'd24;
  localparam logic [31:0] IX_CUR_X   = 32'd25;
  localparam logic [31:0] IX_CUR_Y   = 32'd26;
  localparam logic [31:0] IX_CUR_ON  = 32'd27;
  localparam logic [31:0] IX_SCR_CNT = 32'd29;
  localparam logic [31:0] IX_PAL_LO  = 32'd1024;
  localparam logic [31:0] IX_PAL_HI  = 32'd1791;
  localparam logic [31:0] IX_SCR_LO  = 32'd1792;

  localparam logic [31:0] VER_BASE   = 32'h9000_0000;
  localparam logic [31:0] VER_TOP    = 32'h9000_0002;

  localparam logic [31:0] CAP_FILL   = 32'h0000_0001;
  localparam logic [31:0] CAP_COPY   = 32'h0000_0002;
  localparam logic [31:0] CAP_CURSOR = 32'h0000_00E0;

  localparam logic [31:0] CUR_HIDE   = 32'd0;
  localparam logic [31:0] CUR_SHOW   = 32'd1;

endpackage

// File: rtl/dispreg_decode.sv
module dispreg_decode
  import dispreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STRIDE = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             port_o
);
  localparam logic [ADDR_W-1:0] OFF_VAL = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] OFF_FW  = ADDR_W'(2 * STRIDE);

  always_comb begin
    if (addr_i == '0)           port_o = PORT_IDX;
    else if (addr_i == OFF_VAL) port_o = PORT_VAL;
    else if (addr_i == OFF_FW)  port_o = PORT_FW;
    else                        port_o = PORT_NONE;
  end
endmodule

// File: rtl/dispreg_mode.sv
module dispreg_mode
  import dispreg_pkg::*;
#(
  parameter int          DIM_W      = 12,
  parameter int          MAX_WIDTH  = 2368,
  parameter int          MAX_HEIGHT = 1770,
  parameter int          DEF_WIDTH  = 640,
  parameter int          DEF_HEIGHT = 480,
  parameter logic [31:0] RST_ID     = 32'h9000_0002
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      wdata_i,
  input  logic             we_id_i,
  input  logic             we_en_i,
  input  logic             we_cfg_i,
  input  logic             we_w_i,
  input  logic             we_h_i,
  output logic [31:0]      id_o,
  output logic             enable_o,
  output logic             config_o,
  output logic [DIM_W-1:0] width_o,
  output logic [DIM_W-1:0] height_o
);
  localparam logic [31:0] LIM_W = 32'(MAX_WIDTH);
  localparam logic [31:0] LIM_H = 32'(MAX_HEIGHT);

  logic id_ok, w_ok, h_ok;
  assign id_ok = (wdata_i >= VER_BASE) && (wdata_i <= VER_TOP);
  assign w_ok  = wdata_i <= LIM_W;
  assign h_ok  = wdata_i <= LIM_H;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o     <= RST_ID;
      enable_o <= 1'b0;
      config_o <= 1'b0;
      width_o  <= DIM_W'(DEF_WIDTH);
      height_o <= DIM_W'(DEF_HEIGHT);
    end else begin
      if (we_id_i && id_ok) id_o     <= wdata_i;
      if (we_en_i)          enable_o <= |wdata_i;
      if (we_cfg_i)         config_o <= |wdata_i;
      if (we_w_i && w_ok)   width_o  <= wdata_i[DIM_W-1:0];
      if (we_h_i && h_ok)   height_o <= wdata_i[DIM_W-1:0];
    end
  end
endmodule

// File: rtl/dispreg_cursor.sv
module dispreg_cursor
  import dispreg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] wdata_i,
  input  logic        we_id_i,
  input  logic        we_x_i,
  input  logic        we_y_i,
  input  logic        we_on_i,
  output logic [31:0] cur_id_o,
  output logic [31:0] cur_x_o,
  output logic [31:0] cur_y_o,
  output logic        cur_on_o,
  output logic        cur_upd_o
);
  logic show, hide;
  assign show = (wdata_i == CUR_SHOW);
  assign hide = (wdata_i == CUR_HIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_id_o  <= '0;
      cur_x_o   <= '0;
      cur_y_o   <= '0;
      cur_on_o  <= 1'b0;
      cur_upd_o <= 1'b0;
    end else begin
      if (we_id_i) cur_id_o <= wdata_i;
      if (we_x_i)  cur_x_o  <= wdata_i;
      if (we_y_i)  cur_y_o  <= wdata_i;
      // codes other than show/hide keep the flag
      if (we_on_i && show) cur_on_o <= 1'b1;
      if (we_on_i && hide) cur_on_o <= 1'b0;
      cur_upd_o <= we_on_i && (show || hide);
    end
  end
endmodule

// File: rtl/dispreg_scratch.sv
module dispreg_scratch #(
  parameter int N = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] idx_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic        hit_o,
  output logic [31:0] rdata_o
);
  localparam int          SW   = (N > 1) ? $clog2(N) : 1;
  localparam logic [31:0] BASE = dispreg_pkg::IX_SCR_LO;
  localparam logic [31:0] LAST = BASE + 32'(N);

  logic [31:0]   rel;
  logic [SW-1:0] off;
  logic [31:0]   words [N];

  assign rel   = idx_i - BASE;
  assign off   = rel[SW-1:0];
  assign hit_o = (idx_i >= BASE) && (idx_i < LAST);

  for (genvar g = 0; g < N; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              words[g] <= '0;
      else if (we_i && hit_o && off == SW'(g))  words[g] <= wdata_i;
    end
  end

  assign rdata_o = hit_o ? words[off] : '0;
endmodule

// File: rtl/dispreg_port.sv
module dispreg_port
  import dispreg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int VERSION    = 2,
  parameter int STRIDE     = (VERSION == 2) ? 1 : 4,
  parameter int DIM_W      = 12,
  parameter int MAX_WIDTH  = 2368,
  parameter int MAX_HEIGHT = 1770,
  parameter int DEF_WIDTH  = 640,
  parameter int DEF_HEIGHT = 480,
  parameter int PIX_BITS   = 32,
  parameter int SCRATCH_N  = 64,
  parameter bit CURSOR_CAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              enable_o,
  output logic              config_o,
  output logic [DIM_W-1:0]  width_o,
  output logic [DIM_W-1:0]  height_o,
  output logic              sync_o,
  output logic [31:0]       cur_id_o,
  output logic [31:0]       cur_x_o,
  output logic [31:0]       cur_y_o,
  output logic              cur_on_o,
  output logic              cur_upd_o
);
  localparam logic [31:0] RST_ID    = VER_BASE | 32'(VERSION);
  localparam logic [31:0] DEPTH_RD  = (PIX_BITS == 32) ? 32'd24 : 32'(PIX_BITS);
  localparam logic [31:0] CAPS_RD   = CAP_FILL | CAP_COPY | (CURSOR_CAP ? CAP_CURSOR : 32'd0);

  port_e       port;
  logic [31:0] idx_q;
  logic        val_wr;
  logic [31:0] id_q;
  logic [31:0] scr_rdata;
  logic        scr_hit;
  logic [31:0] pitch;
  logic [31:0] val_rd;
  logic [31:0] port_rd;

  dispreg_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_decode (
    .addr_i (addr_i),
    .port_o (port)
  );

  assign val_wr = wr_i && (port == PORT_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (wr_i && port == PORT_IDX) idx_q <= wdata_i;
  end

  dispreg_mode #(
    .DIM_W(DIM_W), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT),
    .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT), .RST_ID(RST_ID)
  ) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdata_i  (wdata_i),
    .we_id_i  (val_wr && idx_q == IX_ID),
    .we_en_i  (val_wr && idx_q == IX_ENABLE),
    .we_cfg_i (val_wr && idx_q == IX_CONFIG),
    .we_w_i   (val_wr && idx_q == IX_WIDTH),
    .we_h_i   (val_wr && idx_q == IX_HEIGHT),
    .id_o     (id_q),
    .enable_o (enable_o),
    .config_o (config_o),
    .width_o  (width_o),
    .height_o (height_o)
  );

  dispreg_cursor u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wdata_i   (wdata_i),
    .we_id_i   (val_wr && idx_q == IX_CUR_ID),
    .we_x_i    (val_wr && idx_q == IX_CUR_X),
    .we_y_i    (val_wr && idx_q == IX_CUR_Y),
    .we_on_i   (val_wr && idx_q == IX_CUR_ON),
    .cur_id_o  (cur_id_o),
    .cur_x_o   (cur_x_o),
    .cur_y_o   (cur_y_o),
    .cur_on_o  (cur_on_o),
    .cur_upd_o (cur_upd_o)
  );

  dispreg_scratch #(.N(SCRATCH_N)) u_scratch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx_q),
    .we_i    (val_wr),
    .wdata_i (wdata_i),
    .hit_o   (scr_hit),
    .rdata_o (scr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_o <= 1'b0;
    else         sync_o <= val_wr && idx_q == IX_SYNC;
  end

  assign pitch = (32'(width_o) * 32'(PIX_BITS)) >> 3;

  always_comb begin
    unique case (idx_q)
      IX_ID:      val_rd = id_q;
      IX_ENABLE:  val_rd = {31'd0, enable_o};
      IX_WIDTH:   val_rd = 32'(width_o);
      IX_HEIGHT:  val_rd = 32'(height_o);
      IX_MAXW:    val_rd = 32'(MAX_WIDTH);
      IX_MAXH:    val_rd = 32'(MAX_HEIGHT);
      IX_DEPTH:   val_rd = DEPTH_RD;
      IX_BPP:     val_rd = 32'(PIX_BITS);
      IX_PITCH:   val_rd = pitch;
      IX_CAPS:    val_rd = CAPS_RD;
      IX_CONFIG:  val_rd = {31'd0, config_o};
      IX_CUR_ID:  val_rd = cur_id_o;
      IX_CUR_X:   val_rd = cur_x_o;
      IX_CUR_Y:   val_rd = cur_y_o;
      IX_CUR_ON:  val_rd = {31'd0, cur_on_o};
      IX_SCR_CNT: val_rd = 32'(SCRATCH_N);
      // palette window and unlisted indices read zero
      default:    val_rd = scr_hit ? scr_rdata : 32'd0;
    endcase
  end

  always_comb begin
    unique case (port)
      PORT_IDX: port_rd = idx_q;
      PORT_VAL: port_rd = val_rd;
      PORT_FW:  port_rd = 32'd0;
      default:  port_rd = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= port_rd;
  end
endmodule

// File: rtl/dispreg_port_chk.sv
module dispreg_port_chk #(
  parameter int DIM_W      = 12,
  parameter int MAX_WIDTH  = 2368,
  parameter int MAX_HEIGHT = 1770
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [31:0]      rdata_o,
  input logic             enable_o,
  input logic             config_o,
  input logic [DIM_W-1:0] width_o,
  input logic [DIM_W-1:0] height_o,
  input logic             sync_o,
  input logic             cur_on_o,
  input logic             cur_upd_o
);
  // R4
  width_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(width_o) <= 32'(MAX_WIDTH));
  // R4
  height_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(height_o) <= 32'(MAX_HEIGHT));
  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(width_o) && $stable(height_o)));
  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(enable_o) && $stable(config_o)));
  // R8
  sync_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !sync_o);
  // R10
  upd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !cur_upd_o);
  // R10
  vis_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_on_o != $past(cur_on_o)) |-> cur_upd_o);
  // R14
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind dispreg_port dispreg_port_chk #(
  .DIM_W(DIM_W), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .enable_o  (enable_o),
  .config_o  (config_o),
  .width_o   (width_o),
  .height_o  (height_o),
  .sync_o    (sync_o),
  .cur_on_o  (cur_on_o),
  .cur_upd_o (cur_upd_o)
);

// File: tb/dispreg_port_bench.sv
module dispreg_port_bench;
  localparam int AW   = 4;
  localparam int STR  = 4;
  localparam int DW   = 8;
  localparam int MW   = 64;
  localparam int MH   = 40;
  localparam int DEFW = 32;
  localparam int DEFH = 24;
  localparam int NS   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          en, cfg, sync, con, cupd;
  logic [DW-1:0] wid, hgt;
  logic [31:0]   cid, cx, cy;

  int n_chk = 0, n_bad = 0;
  logic last_sync, last_upd;
  logic [31:0] rv;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dispreg_port #(
    .ADDR_W(AW), .VERSION(1), .STRIDE(STR), .DIM_W(DW), .MAX_WIDTH(MW),
    .MAX_HEIGHT(MH), .DEF_WIDTH(DEFW), .DEF_HEIGHT(DEFH), .PIX_BITS(32),
    .SCRATCH_N(NS), .CURSOR_CAP(1'b1)
  ) u_dispreg_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .enable_o(en), .config_o(cfg),
    .width_o(wid), .height_o(hgt), .sync_o(sync), .cur_id_o(cid),
    .cur_x_o(cx), .cur_y_o(cy), .cur_on_o(con), .cur_upd_o(cupd)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic port_wr(input int off, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(off); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    last_sync = sync;
    last_upd  = cupd;
  endtask

  task automatic port_rd(input int off, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(off); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic set_reg(input logic [31:0] ix, input logic [31:0] v);
    port_wr(0, ix);
    port_wr(STR, v);
  endtask

  task automatic get_reg(input logic [31:0] ix, output logic [31:0] v);
    port_wr(0, ix);
    port_rd(STR, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] exp_v, exp_w, held;
    logic exp_on;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    port_rd(0, rv);          chk("R2 reset index", rv, 32'd0);
    chk("R7 reset enable", {31'd0, en}, 32'd0);
    chk("R4 reset width", 32'(wid), 32'(DEFW));
    chk("R4 reset height", 32'(hgt), 32'(DEFH));
    get_reg(32'd0, rv);      chk("R3 reset id", rv, 32'h9000_0001);

    // R1 sweep every port offset
    port_wr(0, 32'd29);
    for (int o = 0; o < 16; o++) begin
      port_rd(o, rv);
      if (o == 0)            chk("R1 index port", rv, 32'd29);
      else if (o == STR)     chk("R1 value port", rv, 32'(NS));
      else if (o == 2 * STR) chk("R1 fw port", rv, 32'd0);
      else                   chk("R1 unmapped", rv, 32'hFFFF_FFFF);
    end
    port_wr(2 * STR, 32'h55);
    port_rd(0, rv);          chk("R1 fw write ignored", rv, 32'd29);
    port_wr(0, 32'hDEAD_BEEF);
    port_rd(0, rv);          chk("R2 index readback", rv, 32'hDEAD_BEEF);

    // R3 version sweep around the valid codes
    exp_v = 32'h9000_0001;
    for (int k = -3; k <= 4; k++) begin
      logic [31:0] c;
      c = 32'h9000_0000 + 32'(k);
      set_reg(32'd0, c);
      if (k >= 0 && k <= 2) exp_v = c;
      get_reg(32'd0, rv);    chk("R3 id write", rv, exp_v);
    end

    // R4 R5 width sweep with pitch
    exp_w = 32'(DEFW);
    for (int w = 0; w <= MW + 3; w++) begin
      set_reg(32'd2, 32'(w));
      if (w <= MW) exp_w = 32'(w);
      chk("R4 width_o", 32'(wid), exp_w);
      get_reg(32'd12, rv);   chk("R5 pitch", rv, exp_w * 32 / 8);
    end
    set_reg(32'd2, 32'h8000_0000);
    chk("R4 huge width ignored", 32'(wid), exp_w);
    exp_w = 32'(DEFH);
    for (int h = MH - 2; h <= MH + 2; h++) begin
      set_reg(32'd3, 32'(h));
      if (h <= MH) exp_w = 32'(h);
      get_reg(32'd3, rv);    chk("R4 height", rv, exp_w);
    end
    get_reg(32'd4, rv);      chk("R4 max width", rv, 32'(MW));
    get_reg(32'd5, rv);      chk("R4 max height", rv, 32'(MH));
    get_reg(32'd6, rv);      chk("R5 depth", rv, 32'd24);
    get_reg(32'd7, rv);      chk("R5 bpp", rv, 32'd32);
    get_reg(32'd17, rv);     chk("R6 caps", rv, 32'h0000_00E3);

    // R7 flags
    set_reg(32'd1, 32'd5);   chk("R7 enable set", {31'd0, en}, 32'd1);
    set_reg(32'd20, 32'h100);chk("R7 config set", {31'd0, cfg}, 32'd1);
    get_reg(32'd20, rv);     chk("R7 config read", rv, 32'd1);
    set_reg(32'd1, 32'd0);   chk("R7 enable clear", {31'd0, en}, 32'd0);
    get_reg(32'd1, rv);      chk("R7 enable read", rv, 32'd0);

    // R8 sync pulse
    set_reg(32'd21, 32'd1);  chk("R8 sync pulse", {31'd0, last_sync}, 32'd1);
    @(negedge clk);          chk("R8 sync one cycle", {31'd0, sync}, 32'd0);
    set_reg(32'd20, 32'd1);  chk("R8 no sync other reg", {31'd0, last_sync}, 32'd0);

    // R9 cursor fields
    set_reg(32'd24, 32'hA5A5_0001); set_reg(32'd25, 32'h1234_5678);
    set_reg(32'd26, 32'hFFFF_0010);
    chk("R9 cur id out", cid, 32'hA5A5_0001);
    chk("R9 cur x out", cx, 32'h1234_5678);
    get_reg(32'd26, rv);     chk("R9 cur y read", rv, 32'hFFFF_0010);

    // R10 cursor-on codes from both states
    exp_on = 1'b0;
    for (int p = 0; p < 12; p++) begin
      logic [31:0] code;
      code = 32'((p * 5 + 1) % 6);
      set_reg(32'd27, code);
      if (code == 32'd1) exp_on = 1'b1;
      if (code == 32'd0) exp_on = 1'b0;
      chk("R10 cur_on", {31'd0, con}, {31'd0, exp_on});
      chk("R10 cur_upd", {31'd0, last_upd}, {31'd0, code <= 32'd1});
      get_reg(32'd27, rv);   chk("R10 cur_on read", rv, {31'd0, exp_on});
    end

    // R11 R12 R13 window sweep around scratch
    for (int i = 1786; i <= 1792 + NS + 2; i++)
      set_reg(32'(i), 32'hA000_0000 + 32'(i));
    for (int i = 1786; i <= 1792 + NS + 2; i++) begin
      get_reg(32'(i), rv);
      if (i >= 1792 && i < 1792 + NS) chk("R12 scratch", rv, 32'hA000_0000 + 32'(i));
      else if (i <= 1791)             chk("R11 palette", rv, 32'd0);
      else                            chk("R12 past scratch", rv, 32'd0);
    end
    set_reg(32'd1024, 32'h77); get_reg(32'd1024, rv); chk("R11 palette low", rv, 32'd0);
    foreach (held[b]) begin end
    for (int u = 8; u <= 11; u++) begin
      set_reg(32'(u), 32'hFFFF_FFFF);
      get_reg(32'(u), rv);   chk("R13 unknown", rv, 32'd0);
    end
    set_reg(32'd5000, 32'h1); get_reg(32'd5000, rv); chk("R13 unknown high", rv, 32'd0);
    get_reg(32'd2, rv);      chk("R13 width untouched", rv, 32'(MW));

    // R14 registered read holds
    get_reg(32'd25, held);
    port_wr(0, 32'd4);
    repeat (3) @(negedge clk);
    chk("R14 rdata held", rdata, held);
    @(negedge clk); addr = AW'(STR); rd = 1'b1;
    chk("R14 not before edge", rdata, held);
    @(negedge clk); rd = 1'b0;
    chk("R14 after edge", rdata, 32'(MW));

    finish_run();
  end
endmodule